// File: doc/BRIEF.md
# Dual-Port PS/2 Serial Controller

This block manages two independent PS/2 ports, typically one keyboard and one mouse. Each port has its own serial engine. The engine receives 11-bit frames that the device clocks in. It also sends one byte at a time from host to device. The block never drives the PS/2 lines high. It only pulls them low, through separate clock and data pulldown outputs, so external open-collector circuitry forms the actual bus. Clock and data inputs are synchronized with two flip-flops. The clock is then passed through a stability filter before its falling edges are detected.

Software reaches the ports through a simple write strobe, address and data port. Reads are combinational and depend only on the address. Port k occupies a 32-byte window at byte address k*0x1000, and every port has the same register set. That set holds received data, transmit data, sticky event flags, and an event mask. The flags are cleared by writing ones, and the mask has separate set and clear locations. There is also a software reset. One interrupt line per port is the OR of its flagged, unmasked events. A transmit that stalls because the device stops clocking is ended by a timeout, which raises its own event.

Top module: `ps2c_ctrl`

## Requirements
- R1: After reset, every pulldown output is low, every irq bit is low, and the received data, transmit data, event flag and mask registers of both ports all read 0.
- R2: Port k decodes word-aligned byte offsets inside a window at k*0x1000, as follows:
  - 0x00 write: bit 0 = 1 requests a software reset.
  - 0x04 read: bit 0 = busy.
  - 0x08 read: received byte.
  - 0x0C: transmit byte.
  - 0x10 read: event flags.
  - 0x14: flag clear; a read returns the flags.
  - 0x18: mask set; a read returns the mask.
  - 0x1C: mask clear; a read returns the mask.
- R3: A receive frame has the following form, with every bit taken at a falling edge of the device clock. If the frame has correct parity and a stop bit of 1, the received byte is stored and flag bit 0 is set.
  - A start bit of 0.
  - Eight data bits, LSB first.
  - An odd parity bit, so that the data bits and the parity bit together hold an odd number of ones.
  - A stop bit.
- R4: A frame with wrong parity or a stop bit of 0 sets flag bit 1 and leaves the received byte unchanged.
- R5: A write to 0x0C while the port is idle starts a transmit with the following line sequence. Clock and data pulldowns are never asserted together.
  - The clock pulldown is held for exactly INHIBIT_CYC cycles.
  - In the cycle the clock pulldown is released, the data pulldown is asserted as the start bit.
- R6: After each device clock falling edge the host places the next bit on the data line, in this order:
  - the eight data bits, LSB first;
  - the odd parity bit;
  - a released stop bit.

  On the 11th falling edge the host samples the data line. A low level sets flag bit 2 (acknowledged) and a high level sets flag bit 3 (not acknowledged).
- R7: If no device clock falling edge arrives for TOUT_CYC cycles while a transmit is in progress, the port does three things:
  - sets flag bit 4;
  - releases both pulldowns;
  - returns to idle with busy = 0.
- R8: A write to 0x0C while busy reads 1 is ignored. Both the byte sent and the byte read back at 0x0C stay as they were.
- R9: Writing 1s to 0x14 clears those flag bits, and 0 bits have no effect.
- R10: Writing 1s to 0x18 sets mask bits and writing 1s to 0x1C clears them. Zero bits have no effect at either location.
- R11: irq[k] is high exactly when some flag bit of port k and the same mask bit are both 1.
- R12: A software reset of one port clears that port's flags, mask, received byte, transmit byte and engine state. The other port is not affected, and a write of 0 to bit 0 does nothing.
- R13: A clock low pulse shorter than FILT_LEN cycles is not taken as an edge, so the next frame is still received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 13 | Register byte address (bit 12 selects the port) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| ps2_clk_in | input | 2 | PS/2 clock line level, one bit per port |
| ps2_dat_in | input | 2 | PS/2 data line level, one bit per port |
| ps2_clk_pd | output | 2 | Clock pulldown enable, one bit per port |
| ps2_dat_pd | output | 2 | Data pulldown enable, one bit per port |
| irq | output | 2 | Masked event interrupt, one bit per port |

## Verification
Results become visible at different times, and the bench samples each one accordingly:
- Register writes take effect at the clock edge they are presented on. Reads and irq are combinational, so the bench sets the address on a falling clock edge and reads shortly after, and observes the result of a write from the next cycle.
- A serial event lands about two synchronizer cycles plus FILT_LEN filter cycles plus one register cycle after a device clock falling edge. The device model therefore samples host data at the end of each low phase, and reads flags at least half a device clock period after the last edge.
- The inhibit length is counted exactly, one count per falling system clock edge on which the clock pulldown is high.
- The timeout is checked on both sides of its deadline, once well before TOUT_CYC and once after it.

// File: rtl/ps2c_pkg.sv
package ps2c_pkg;

    localparam int BYTE_W   = 8;
    localparam int EVT_W    = 5;
    localparam int PORT_LSB = 12;

    // event flags, bit 0 first: rx_ok, rx_err, tx_ok, tx_nack, tx_tout
    typedef struct packed {
        logic tx_tout;
        logic tx_nack;
        logic tx_ok;
        logic rx_err;
        logic rx_ok;
    } ps2c_evt_t;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_RX,
        ENG_INH,
        ENG_TXSH,
        ENG_TXACK
    } ps2c_eng_e;

    // register word index inside a port window (byte offset / 4)
    typedef enum logic [2:0] {
        OFS_SRST  = 3'd0,
        OFS_BUSY  = 3'd1,
        OFS_RXD   = 3'd2,
        OFS_TXD   = 3'd3,
        OFS_STAT  = 3'd4,
        OFS_STCLR = 3'd5,
        OFS_MSET  = 3'd6,
        OFS_MCLR  = 3'd7
    } ps2c_ofs_e;

    function automatic logic odd_par(input logic [BYTE_W-1:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/ps2c_line_sync.sv
module ps2c_line_sync #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_raw,
    input  logic dat_raw,
    output logic clk_fall,
    output logic dat_s
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [1:0]       c_sync;
    logic [1:0]       d_sync;
    logic             clk_lvl;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_sync   <= 2'b11;
            d_sync   <= 2'b11;
            clk_lvl  <= 1'b1;
            cnt      <= '0;
            clk_fall <= 1'b0;
        end else begin
            c_sync   <= {c_sync[0], clk_raw};
            d_sync   <= {d_sync[0], dat_raw};
            clk_fall <= 1'b0;
            if (c_sync[1] == clk_lvl) begin
                cnt <= '0;
            end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
                cnt      <= '0;
                clk_lvl  <= c_sync[1];
                clk_fall <= clk_lvl;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign dat_s = d_sync[1];

endmodule

// File: rtl/ps2c_engine.sv
module ps2c_engine
    import ps2c_pkg::*;
#(
    parameter int FILT_LEN    = 8,
    parameter int INHIBIT_CYC = 5000,
    parameter int TOUT_CYC    = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_raw,
    input  logic              dat_raw,
    input  logic              tx_go,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              clk_pd,
    output logic              dat_pd,
    output logic              busy,
    output logic [BYTE_W-1:0] rx_byte,
    output ps2c_evt_t         evt
);
    localparam int TMR_MAX = (INHIBIT_CYC > TOUT_CYC) ? INHIBIT_CYC : TOUT_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int SH_W    = BYTE_W + 2;

    ps2c_eng_e        st;
    logic [3:0]       bitn;
    logic [SH_W-1:0]  sh;
    logic [TMR_W-1:0] tmr;
    logic             drv_low;
    logic             fall;
    logic             dat_s;
    logic             tmo;

    ps2c_line_sync #(.FILT_LEN(FILT_LEN)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .clk_raw  (clk_raw),
        .dat_raw  (dat_raw),
        .clk_fall (fall),
        .dat_s    (dat_s)
    );

    assign tmo = (tmr == TMR_W'(TOUT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ENG_IDLE;
            bitn    <= '0;
            sh      <= '0;
            tmr     <= '0;
            drv_low <= 1'b0;
            rx_byte <= '0;
            evt     <= '0;
        end else begin
            evt <= '0;
            unique case (st)
                ENG_IDLE: begin
                    tmr  <= '0;
                    bitn <= '0;
                    if (tx_go) begin
                        st <= ENG_INH;
                        sh <= {1'b1, odd_par(tx_byte), tx_byte};
                    end else if (fall && !dat_s) begin
                        st <= ENG_RX;
                    end
                end
                ENG_RX: begin
                    if (fall) begin
                        tmr  <= '0;
                        bitn <= bitn + 1'b1;
                        sh   <= {dat_s, sh[SH_W-1:1]};
                        if (bitn == 4'd9) begin
                            st <= ENG_IDLE;
                            if (dat_s && (^sh[SH_W-1:1])) begin
                                rx_byte    <= sh[SH_W-2:1];
                                evt.rx_ok  <= 1'b1;
                            end else begin
                                evt.rx_err <= 1'b1;
                            end
                        end
                    end else if (tmo) begin
                        st <= ENG_IDLE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ENG_INH: begin
                    if (tmr == TMR_W'(INHIBIT_CYC - 1)) begin
                        st      <= ENG_TXSH;
                        tmr     <= '0;
                        drv_low <= 1'b1;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ENG_TXSH, ENG_TXACK: begin
                    if (fall) begin
                        tmr <= '0;
                        if (st == ENG_TXSH) begin
                            drv_low <= ~sh[0];
                            sh      <= {1'b1, sh[SH_W-1:1]};
                            bitn    <= bitn + 1'b1;
                            if (bitn == 4'd9) st <= ENG_TXACK;
                        end else begin
                            st          <= ENG_IDLE;
                            drv_low     <= 1'b0;
                            evt.tx_ok   <= ~dat_s;
                            evt.tx_nack <= dat_s;
                        end
                    end else if (tmo) begin
                        st          <= ENG_IDLE;
                        drv_low     <= 1'b0;
                        evt.tx_tout <= 1'b1;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    assign clk_pd = (st == ENG_INH);
    assign dat_pd = drv_low;
    assign busy   = (st != ENG_IDLE);

endmodule

// File: rtl/ps2c_port.sv
module ps2c_port
    import ps2c_pkg::*;
#(
    parameter int FILT_LEN    = 8,
    parameter int INHIBIT_CYC = 5000,
    parameter int TOUT_CYC    = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  ps2c_ofs_e         ofs,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              line_clk,
    input  logic              line_dat,
    output logic              clk_pd,
    output logic              dat_pd,
    output logic              irq
);
    logic              prst;
    logic              tx_go;
    logic              busy;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] txd;
    logic [EVT_W-1:0]  stat;
    logic [EVT_W-1:0]  mask;
    logic [EVT_W-1:0]  w_clr;
    logic [EVT_W-1:0]  w_mset;
    logic [EVT_W-1:0]  w_mclr;
    ps2c_evt_t         evt;

    assign prst   = rst | (wr && ofs == OFS_SRST && wdata[0]);
    assign tx_go  = wr && ofs == OFS_TXD && !busy;
    assign w_clr  = (wr && ofs == OFS_STCLR) ? wdata[EVT_W-1:0] : '0;
    assign w_mset = (wr && ofs == OFS_MSET)  ? wdata[EVT_W-1:0] : '0;
    assign w_mclr = (wr && ofs == OFS_MCLR)  ? wdata[EVT_W-1:0] : '0;

    ps2c_engine #(
        .FILT_LEN    (FILT_LEN),
        .INHIBIT_CYC (INHIBIT_CYC),
        .TOUT_CYC    (TOUT_CYC)
    ) u_eng (
        .clk     (clk),
        .rst     (prst),
        .clk_raw (line_clk),
        .dat_raw (line_dat),
        .tx_go   (tx_go),
        .tx_byte (wdata),
        .clk_pd  (clk_pd),
        .dat_pd  (dat_pd),
        .busy    (busy),
        .rx_byte (rx_byte),
        .evt     (evt)
    );

    always_ff @(posedge clk) begin
        if (prst) begin
            txd  <= '0;
            stat <= '0;
            mask <= '0;
        end else begin
            if (tx_go) txd <= wdata;
            stat <= (stat & ~w_clr) | evt;
            mask <= (mask | w_mset) & ~w_mclr;
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_BUSY:             rdata = BYTE_W'(busy);
            OFS_RXD:              rdata = rx_byte;
            OFS_TXD:              rdata = txd;
            OFS_STAT, OFS_STCLR:  rdata = BYTE_W'(stat);
            OFS_MSET, OFS_MCLR:   rdata = BYTE_W'(mask);
            default:              rdata = '0;
        endcase
    end

    assign irq = |(stat & mask);

endmodule

// File: rtl/ps2c_ctrl.sv
module ps2c_ctrl
    import ps2c_pkg::*;
#(
    parameter int NPORT       = 2,
    parameter int FILT_LEN    = 8,
    parameter int INHIBIT_CYC = 5000,
    parameter int TOUT_CYC    = 10000,
    localparam int SEL_W      = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int ADDR_W     = PORT_LSB + SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [NPORT-1:0]  ps2_clk_in,
    input  logic [NPORT-1:0]  ps2_dat_in,
    output logic [NPORT-1:0]  ps2_clk_pd,
    output logic [NPORT-1:0]  ps2_dat_pd,
    output logic [NPORT-1:0]  irq
);
    logic              in_win;
    logic [SEL_W-1:0]  sel;
    ps2c_ofs_e         ofs;
    logic [BYTE_W-1:0] port_rd [NPORT];

    assign in_win = (reg_addr[PORT_LSB-1:5] == '0) && (reg_addr[1:0] == 2'b00);
    assign sel    = reg_addr[ADDR_W-1:PORT_LSB];
    assign ofs    = ps2c_ofs_e'(reg_addr[4:2]);

    for (genvar k = 0; k < NPORT; k++) begin : g_port
        ps2c_port #(
            .FILT_LEN    (FILT_LEN),
            .INHIBIT_CYC (INHIBIT_CYC),
            .TOUT_CYC    (TOUT_CYC)
        ) u_port (
            .clk      (clk),
            .rst      (rst),
            .wr       (reg_we && in_win && sel == SEL_W'(k)),
            .ofs      (ofs),
            .wdata    (reg_wdata),
            .rdata    (port_rd[k]),
            .line_clk (ps2_clk_in[k]),
            .line_dat (ps2_dat_in[k]),
            .clk_pd   (ps2_clk_pd[k]),
            .dat_pd   (ps2_dat_pd[k]),
            .irq      (irq[k])
        );
    end

    assign reg_rdata = (in_win && int'(sel) < NPORT) ? port_rd[sel] : '0;

endmodule

// File: rtl/ps2c_checks.sv
module ps2c_checks
    import ps2c_pkg::*;
#(
    parameter int NPORT   = 2,
    localparam int SEL_W  = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int ADDR_W = PORT_LSB + SEL_W
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic [NPORT-1:0]  ps2_clk_pd,
    input logic [NPORT-1:0]  ps2_dat_pd,
    input logic [NPORT-1:0]  irq
);
    localparam logic [BYTE_W-1:0] EVT_ALL = BYTE_W'((1 << EVT_W) - 1);

    for (genvar k = 0; k < NPORT; k++) begin : g_chk
        logic wr_srst;
        logic wr_mclr_all;
        assign wr_srst     = reg_we && reg_addr == ADDR_W'(k << PORT_LSB) && reg_wdata[0];
        assign wr_mclr_all = reg_we && reg_addr == ADDR_W'((k << PORT_LSB) + 'h1C)
                             && (&(reg_wdata | ~EVT_ALL));

        a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !ps2_clk_pd[k] && !ps2_dat_pd[k] && !irq[k]);

        a_r5_never_both_pd: assert property (@(posedge clk) disable iff (rst)
            !(ps2_clk_pd[k] && ps2_dat_pd[k]));

        a_r5_start_after_inhibit: assert property (@(posedge clk) disable iff (rst)
            $fell(ps2_clk_pd[k]) && !$past(wr_srst) |-> ps2_dat_pd[k]);

        a_r10_mask_clear_quiet: assert property (@(posedge clk) disable iff (rst)
            wr_mclr_all |=> !irq[k]);

        a_r12_srst_quiet: assert property (@(posedge clk) disable iff (rst)
            wr_srst |=> !irq[k] && !ps2_clk_pd[k] && !ps2_dat_pd[k]);
    end

endmodule

bind ps2c_ctrl ps2c_checks #(.NPORT(NPORT)) u_chk (.*);

// File: tb/ps2c_ctrl_test.sv
module ps2c_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP     = 2;
    localparam int FILT   = 4;
    localparam int INH    = 200;
    localparam int TOUT   = 400;
    localparam int HP     = 30;
    localparam int AW     = 13;
    localparam int WD_CYC = 100000;

    localparam logic [4:0] O_SRST = 5'h00, O_BUSY = 5'h04, O_RXD = 5'h08, O_TXD = 5'h0C,
                           O_STAT = 5'h10, O_STCLR = 5'h14, O_MSET = 5'h18, O_MCLR = 5'h1C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NP-1:0] dev_clk = '1;
    logic [NP-1:0] dev_dat = '1;
    logic [NP-1:0] ps2_clk_in, ps2_dat_in, ps2_clk_pd, ps2_dat_pd, irq;

    int   checks = 0;
    int   failures = 0;
    logic done = 1'b0;
    logic both_seen = 1'b0;

    assign ps2_clk_in = dev_clk & ~ps2_clk_pd;
    assign ps2_dat_in = dev_dat & ~ps2_dat_pd;

    ps2c_ctrl #(.NPORT(NP), .FILT_LEN(FILT), .INHIBIT_CYC(INH), .TOUT_CYC(TOUT)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ps2_clk_in(ps2_clk_in), .ps2_dat_in(ps2_dat_in),
        .ps2_clk_pd(ps2_clk_pd), .ps2_dat_pd(ps2_dat_pd), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (!rst && |(ps2_clk_pd & ps2_dat_pd)) both_seen <= 1'b1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int p, input logic [4:0] o, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(p * 4096 + int'(o)); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int p, input logic [4:0] o, output logic [7:0] d);
        @(negedge clk);
        reg_addr = AW'(p * 4096 + int'(o));
        #1 d = reg_rdata;
    endtask

    task automatic dev_send(input int p, input logic [7:0] b, input logic bad);
        logic [10:0] fr;
        fr = {1'b1, (~^b) ^ bad, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            dev_dat[p] = fr[i];
            wait_cyc(HP); dev_clk[p] = 1'b0;
            wait_cyc(HP); dev_clk[p] = 1'b1;
        end
        dev_dat[p] = 1'b1;
        wait_cyc(HP);
    endtask

    task automatic dev_recv(input int p, input int nclk, input logic ack,
                            output logic [9:0] bits, output int inh, output logic start_ok);
        inh = 0; bits = '0;
        while (!ps2_clk_pd[p]) @(negedge clk);
        while (ps2_clk_pd[p]) begin inh++; @(negedge clk); end
        start_ok = ps2_dat_pd[p];
        wait_cyc(HP);
        for (int i = 1; i <= nclk; i++) begin
            if (i == 11) dev_dat[p] = !ack;
            dev_clk[p] = 1'b0; wait_cyc(HP);
            if (i <= 10) bits[i-1] = ps2_dat_in[p];
            dev_clk[p] = 1'b1; wait_cyc(HP);
        end
        dev_dat[p] = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int p = 0; p < NP; p++) begin
            rd(p, O_RXD, v);  chk("R1 rx data", v, 0);
            rd(p, O_TXD, v);  chk("R1 tx data", v, 0);
            rd(p, O_STAT, v); chk("R1 flags", v, 0);
            rd(p, O_MSET, v); chk("R1 mask", v, 0);
        end
        chk("R1 irq", irq, 0);
        chk("R1 pulldowns", {ps2_clk_pd, ps2_dat_pd}, 0);
    endtask

    task automatic t_rx_good_and_regs();
        logic [7:0] v;
        dev_send(0, 8'hA5, 1'b0);
        rd(0, O_RXD, v);  chk("R3 rx byte", v, 8'hA5);
        rd(0, O_STAT, v); chk("R3 rx_ok flag", v, 8'h01);
        chk("R11 irq masked off", irq[0], 0);
        wr(0, O_MSET, 8'h01); #1 chk("R11 irq on mask", irq[0], 1);
        rd(0, O_MCLR, v); chk("R10 mask readback", v, 8'h01);
        wr(0, O_MSET, 8'h00); rd(0, O_MSET, v); chk("R10 zero set no effect", v, 8'h01);
        wr(0, O_MCLR, 8'h00); rd(0, O_MSET, v); chk("R10 zero clear no effect", v, 8'h01);
        wr(0, O_STCLR, 8'h00); rd(0, O_STAT, v); chk("R9 zero clear no effect", v, 8'h01);
        wr(0, O_STCLR, 8'h01); rd(0, O_STCLR, v); chk("R9 w1c", v, 8'h00);
        chk("R11 irq off after clear", irq[0], 0);
        wr(0, O_MCLR, 8'h01); rd(0, O_MSET, v); chk("R10 mask clear", v, 8'h00);
    endtask

    task automatic t_rx_bad();
        logic [7:0] v;
        dev_send(1, 8'h3C, 1'b1);
        rd(1, O_STAT, v); chk("R4 rx_err flag", v, 8'h02);
        rd(1, O_RXD, v);  chk("R4 rx byte kept", v, 8'h00);
        rd(0, O_STAT, v); chk("R2 other port untouched", v, 8'h00);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        dev_dat[0] = 1'b0; wait_cyc(5);
        dev_clk[0] = 1'b0; wait_cyc(2); dev_clk[0] = 1'b1;
        wait_cyc(20); dev_dat[0] = 1'b1; wait_cyc(20);
        dev_send(0, 8'h5A, 1'b0);
        rd(0, O_STAT, v); chk("R13 frame after glitch ok", v, 8'h01);
        rd(0, O_RXD, v);  chk("R13 rx byte after glitch", v, 8'h5A);
        wr(0, O_STCLR, 8'h1F);
    endtask

    task automatic t_tx_ack();
        logic [7:0] v; logic [9:0] bits; int inh; logic st;
        wr(0, O_TXD, 8'h96);
        dev_recv(0, 11, 1'b1, bits, inh, st);
        chk("R5 inhibit length", inh, INH);
        chk("R5 start bit driven", st, 1);
        chk("R6 data bits", bits[7:0], 8'h96);
        chk("R6 odd parity", bits[8], ~^8'h96);
        chk("R6 stop released", bits[9], 1);
        wait_cyc(HP);
        rd(0, O_STAT, v); chk("R6 ack flag", v, 8'h04);
        rd(0, O_BUSY, v); chk("R6 idle after ack", v, 0);
        rd(0, O_TXD, v);  chk("R2 tx readback", v, 8'h96);
        chk("R5 no dual pulldown", both_seen, 0);
        wr(0, O_STCLR, 8'h1F);
    endtask

    task automatic t_tx_nack_busy();
        logic [7:0] v; logic [9:0] bits; int inh; logic st;
        wr(1, O_TXD, 8'h00);
        rd(1, O_BUSY, v); chk("R8 busy during tx", v, 1);
        wr(1, O_TXD, 8'h7E);
        dev_recv(1, 11, 1'b0, bits, inh, st);
        chk("R8 busy write ignored on line", bits[7:0], 8'h00);
        wait_cyc(HP);
        rd(1, O_TXD, v);  chk("R8 busy write ignored in reg", v, 8'h00);
        rd(1, O_STAT, v); chk("R6 nack flag", v, 8'h0A);
    endtask

    task automatic t_timeout();
        logic [7:0] v; logic [9:0] bits; int inh; logic st;
        wr(0, O_MSET, 8'h10);
        wr(0, O_TXD, 8'h42);
        dev_recv(0, 3, 1'b1, bits, inh, st);
        wait_cyc(TOUT - 100);
        rd(0, O_BUSY, v); chk("R7 still busy before deadline", v, 1);
        wait_cyc(150);
        rd(0, O_STAT, v); chk("R7 timeout flag", v, 8'h10);
        rd(0, O_BUSY, v); chk("R7 idle after timeout", v, 0);
        chk("R7 pulldowns released", {ps2_clk_pd[0], ps2_dat_pd[0]}, 0);
        chk("R11 irq on timeout", irq[0], 1);
    endtask

    task automatic t_soft_reset();
        logic [7:0] v;
        wr(1, O_SRST, 8'h00);
        rd(1, O_STAT, v); chk("R12 zero write no reset", v, 8'h0A);
        wr(0, O_SRST, 8'h01);
        rd(0, O_STAT, v); chk("R12 flags cleared", v, 0);
        rd(0, O_MSET, v); chk("R12 mask cleared", v, 0);
        rd(0, O_RXD, v);  chk("R12 rx byte cleared", v, 0);
        rd(0, O_TXD, v);  chk("R12 tx byte cleared", v, 0);
        chk("R12 irq cleared", irq[0], 0);
        rd(1, O_STAT, v); chk("R12 other port kept", v, 8'h0A);
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        t_reset();
        t_rx_good_and_regs();
        t_rx_bad();
        t_glitch();
        t_tx_ack();
        t_tx_nack_busy();
        t_timeout();
        t_soft_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule